// File: doc/BRIEF.md
# Scan-Mode Conversion Sequencer for a Successive-Approximation ADC

This block is the digital controller that sits in front of a successive-approximation converter core. It runs in a software-started, repeating-scan mode. Software sets an enable level, writes a start bit and writes a group-select field. Once started, the block converts four adjacent analog channels in a fixed order. For each channel it issues a one-cycle start pulse to the core and waits for the core's done strobe. It then latches the result word and raises a one-cycle end-of-conversion interrupt. After the last channel of the group it returns to the first channel on its own, and it keeps scanning until software stops it.

Any write of start = 1 or of the group-select field during a scan throws away the conversion in flight and starts again from the first channel of the (possibly new) group. Writing start = 0 drops the block back to standby. A hardware trigger input is present, but it never starts, restarts or disturbs a scan in this mode. The analog core and the register bus are outside the block. Writes reach the block as one-cycle strobes that carry the written value.

Top module: `adcseq_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `state_o` is 0 (stop), and `conv_start_o`, `irq_o` and `result_o` are all 0.
- R2: A start = 1 write made while `en_i` is 0 is ignored: `state_o` stays 0 and `conv_start_o` stays 0.
- R3: With `en_i` = 1, the stop state moves to standby (`state_o` = 1) on the next cycle. With `en_i` = 0, any state moves to stop (`state_o` = 0) on the next cycle.
- R4: A start = 1 write in standby gives, on the next cycle, `state_o` = 2 (converting), a start pulse, and `conv_ch_o` = group × 4 + 0. Here `conv_ch_o` is {group, 2-bit index}, so group 0 covers channels 0 to 3 and group 1 covers channels 4 to 7. The index steps 0, 1, 2, 3 through the scan.
- R5: Each accepted done strobe makes `result_o` equal to that conversion's data word and pulses `irq_o` for exactly one cycle, both on the next cycle. `result_o` holds its value at all other times, so each full scan produces four interrupts.
- R6: After the done strobe of index 3, the next start pulse goes to index 0 of the same group. The scan repeats with no software action.
- R7: A start = 1 write while converting aborts the conversion in flight. On the next cycle there is a start pulse at index 0 of the current group, and no result or interrupt comes from the aborted conversion.
- R8: A write of the group select while converting aborts, even when the written value equals the current group. On the next cycle there is a start pulse at index 0 of the written group.
- R9: `hw_trig_i` has no effect in any state. During a scan, start pulses occur only in the cycle after an accepted done strobe or after a write.
- R10: A start = 0 write while converting gives standby on the next cycle, with no start pulse and no interrupt. It takes priority over a group-select write in the same cycle, and that group value is still stored.
- R11: A done strobe in the same cycle as an abort is dropped: no result is stored and no interrupt follows.
- R12: `conv_start_o` is a one-cycle pulse at the start of every channel conversion. Done strobes that arrive outside the converting state, or in the cycle of a start pulse, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Converter enable level |
| start_wr_i | input | 1 | One-cycle strobe: start bit written |
| start_val_i | input | 1 | Value written to the start bit |
| chsel_wr_i | input | 1 | One-cycle strobe: group select written |
| chsel_val_i | input | GRP_W | Group value written |
| hw_trig_i | input | 1 | Hardware trigger (no effect in this mode) |
| conv_done_i | input | 1 | Core conversion-done strobe |
| conv_data_i | input | RES_W | Core result word, valid with done |
| conv_start_o | output | 1 | One-cycle start pulse to the core |
| conv_ch_o | output | GRP_W+log2(SCAN_N) | Channel being converted |
| result_o | output | RES_W | Last stored result |
| irq_o | output | 1 | End-of-conversion interrupt pulse |
| state_o | output | 2 | 0 stop, 1 standby, 2 converting |

## Verification
The bench runs two uninterrupted scans on group 0. This separates a correct wrap back to index 0 from a scan that stops or runs on past index 3. It then drives trigger pulses during a scan, where any extra start pulse is visible, and overwrites start and the group select at mid-conversion, including a rewrite with the same group value, to show that the abort comes from the write and not from a change of value. A group write placed exactly on a done strobe separates "abort wins" from "result stored", and a start = 0 write combined with a group write separates the halt priority from a restart.

// File: rtl/adcseq_pkg.sv
// Shared types for the scan sequencer.
// Assumes nothing beyond a 2-bit state code seen at the top-level port.
package adcseq_pkg;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_STBY = 2'd1,
        ST_CONV = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic begin_scan;   // standby -> converting
        logic restart;      // abort and go back to index 0
        logic halt;         // abort and go back to standby
    } seq_cmd_t;

endpackage

// File: rtl/adcseq_cmd.sv
// Write decoder: turns the start and group-select write strobes into
// sequencer commands, with halt taking priority over restart.
// Assumes the write strobes are single-cycle.
module adcseq_cmd
    import adcseq_pkg::*;
(
    input  seq_state_e state_i,
    input  logic       en_i,
    input  logic       start_wr_i,
    input  logic       start_val_i,
    input  logic       chsel_wr_i,
    input  logic       hw_trig_i,
    output seq_cmd_t   cmd_o
);

    logic start_set;
    logic start_clr;
    logic converting;
    logic unused_trig;

    // The trigger has no role in this mode; tie it off explicitly.
    assign unused_trig = hw_trig_i;

    // Classify the start write and the current state.
    always_comb begin
        start_set  = start_wr_i && start_val_i;
        start_clr  = start_wr_i && !start_val_i;
        converting = en_i && (state_i == ST_CONV);
    end

    // Build the prioritised command word.
    always_comb begin
        cmd_o.begin_scan = en_i && (state_i == ST_STBY) && start_set;
        cmd_o.halt       = converting && start_clr;
        cmd_o.restart    = converting && !start_clr && (start_set || chsel_wr_i);
    end

endmodule

// File: rtl/adcseq_fsm.sv
// Operating-state register and converter start pulse.
// Accepts a done strobe only while converting, outside the start-pulse
// cycle and when no abort is happening in the same cycle.
module adcseq_fsm
    import adcseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  seq_cmd_t   cmd_i,
    input  logic       conv_done_i,
    output seq_state_e state_o,
    output logic       conv_start_o,
    output logic       accept_o,
    output logic       clear_idx_o
);

    seq_state_e state_q;
    logic       start_q;

    // Decide whether this cycle's done strobe belongs to a live conversion.
    always_comb begin
        accept_o    = en_i && (state_q == ST_CONV) && !start_q && conv_done_i
                      && !cmd_i.restart && !cmd_i.halt;
        clear_idx_o = cmd_i.begin_scan || cmd_i.restart;
    end

    // State transitions between stop, standby and converting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
        end else if (!en_i) begin
            state_q <= ST_STOP;
        end else begin
            case (state_q)
                ST_STOP: state_q <= ST_STBY;
                ST_STBY: if (cmd_i.begin_scan) state_q <= ST_CONV;
                ST_CONV: if (cmd_i.halt) state_q <= ST_STBY;
                default: state_q <= ST_STOP;
            endcase
        end
    end

    // One-cycle start pulse for every new channel conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
        end else begin
            start_q <= en_i && (cmd_i.begin_scan || cmd_i.restart || accept_o);
        end
    end

    assign state_o      = state_q;
    assign conv_start_o = start_q;

endmodule

// File: rtl/adcseq_scan_idx.sv
// Group register and scan index; forms the channel number {group, index}.
// Assumes SCAN_N is a power of two so that concatenation equals
// group * SCAN_N + index.
module adcseq_scan_idx #(
    parameter int GRP_W  = 1,
    parameter int SCAN_N = 4,
    localparam int IDX_W = (SCAN_N > 1) ? $clog2(SCAN_N) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   chsel_wr_i,
    input  logic [GRP_W-1:0]       chsel_val_i,
    input  logic                   clear_i,
    input  logic                   step_i,
    output logic [GRP_W+IDX_W-1:0] ch_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SCAN_N - 1);

    logic [GRP_W-1:0] grp_q;
    logic [IDX_W-1:0] idx_q;

    // Group select register, written at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q <= '0;
        end else if (chsel_wr_i) begin
            grp_q <= chsel_val_i;
        end
    end

    // Scan index: cleared on scan start or abort, advanced on each result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clear_i) begin
            idx_q <= '0;
        end else if (step_i) begin
            idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
        end
    end

    assign ch_o = {grp_q, idx_q};

endmodule

// File: rtl/adcseq_result.sv
// Result register and end-of-conversion interrupt pulse.
// Assumes conv_data_i is valid in the cycle the done strobe is accepted.
module adcseq_result #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic [RES_W-1:0] conv_data_i,
    output logic [RES_W-1:0] result_o,
    output logic             irq_o
);

    // Capture the result word of each accepted conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
        end else if (accept_i) begin
            result_o <= conv_data_i;
        end
    end

    // One interrupt pulse for each stored result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= accept_i;
        end
    end

endmodule

// File: rtl/adcseq_top.sv
// Scan-mode conversion sequencer: repeats scans over a group of SCAN_N
// adjacent channels, restarting on start or group-select writes.
// Assumes single-cycle write strobes and a core that answers each start
// pulse with one done strobe; the hardware trigger is not used in this mode.
module adcseq_top #(
    parameter int GRP_W  = 1,
    parameter int SCAN_N = 4,
    parameter int RES_W  = 10
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               en_i,
    input  logic                               start_wr_i,
    input  logic                               start_val_i,
    input  logic                               chsel_wr_i,
    input  logic [GRP_W-1:0]                   chsel_val_i,
    input  logic                               hw_trig_i,
    input  logic                               conv_done_i,
    input  logic [RES_W-1:0]                   conv_data_i,
    output logic                               conv_start_o,
    output logic [GRP_W+$clog2(SCAN_N)-1:0]    conv_ch_o,
    output logic [RES_W-1:0]                   result_o,
    output logic                               irq_o,
    output logic [1:0]                         state_o
);
    import adcseq_pkg::*;

    seq_state_e state;
    seq_cmd_t   cmd;
    logic       accept;
    logic       clear_idx;

    adcseq_cmd u_cmd (
        .state_i     (state),
        .en_i        (en_i),
        .start_wr_i  (start_wr_i),
        .start_val_i (start_val_i),
        .chsel_wr_i  (chsel_wr_i),
        .hw_trig_i   (hw_trig_i),
        .cmd_o       (cmd)
    );

    adcseq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en_i),
        .cmd_i        (cmd),
        .conv_done_i  (conv_done_i),
        .state_o      (state),
        .conv_start_o (conv_start_o),
        .accept_o     (accept),
        .clear_idx_o  (clear_idx)
    );

    adcseq_scan_idx #(
        .GRP_W  (GRP_W),
        .SCAN_N (SCAN_N)
    ) u_idx (
        .clk         (clk),
        .rst_n       (rst_n),
        .chsel_wr_i  (chsel_wr_i),
        .chsel_val_i (chsel_val_i),
        .clear_i     (clear_idx),
        .step_i      (accept),
        .ch_o        (conv_ch_o)
    );

    adcseq_result #(
        .RES_W (RES_W)
    ) u_res (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .conv_data_i (conv_data_i),
        .result_o    (result_o),
        .irq_o       (irq_o)
    );

    assign state_o = state;

endmodule

// File: rtl/adcseq_chk.sv
// Port-level property checker for adcseq_top, attached by bind below.
module adcseq_chk #(
    parameter int GRP_W  = 1,
    parameter int SCAN_N = 4,
    parameter int RES_W  = 10,
    localparam int IDX_W = $clog2(SCAN_N)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   en_i,
    input logic                   start_wr_i,
    input logic                   start_val_i,
    input logic                   chsel_wr_i,
    input logic [GRP_W-1:0]       chsel_val_i,
    input logic                   hw_trig_i,
    input logic                   conv_done_i,
    input logic [RES_W-1:0]       conv_data_i,
    input logic                   conv_start_o,
    input logic [GRP_W+IDX_W-1:0] conv_ch_o,
    input logic [RES_W-1:0]       result_o,
    input logic                   irq_o,
    input logic [1:0]             state_o
);

    localparam logic [1:0] S_STOP = 2'd0;
    localparam logic [1:0] S_STBY = 2'd1;
    localparam logic [1:0] S_CONV = 2'd2;

    logic conv_now;
    assign conv_now = en_i && (state_o == S_CONV);

    p_ignore_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && start_wr_i && start_val_i) |=> (state_o == S_STOP && !conv_start_o));

    p_disable_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (state_o == S_STOP));

    p_begin_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && state_o == S_STBY && start_wr_i && start_val_i)
        |=> (state_o == S_CONV && conv_start_o && conv_ch_o[IDX_W-1:0] == '0));

    p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    p_irq_from_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(conv_done_i) && result_o == $past(conv_data_i)));

    p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> $stable(result_o));

    p_restart_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_now && start_wr_i && start_val_i)
        |=> (conv_start_o && !irq_o && conv_ch_o[IDX_W-1:0] == '0));

    p_restart_grp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_now && chsel_wr_i && !(start_wr_i && !start_val_i))
        |=> (conv_start_o && conv_ch_o == {$past(chsel_val_i), IDX_W'(0)}));

    p_trig_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == S_STBY && hw_trig_i && !start_wr_i) |=> !conv_start_o);

    p_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_now && start_wr_i && !start_val_i)
        |=> (state_o == S_STBY && !conv_start_o && !irq_o));

    p_abort_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_now && conv_done_i && (start_wr_i || chsel_wr_i)) |=> !irq_o);

    p_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o);

    p_stby_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != S_CONV) |=> !irq_o);

endmodule

bind adcseq_top adcseq_chk #(
    .GRP_W  (GRP_W),
    .SCAN_N (SCAN_N),
    .RES_W  (RES_W)
) u_chk (.*);

// File: tb/adcseq_top_tb.sv
`timescale 1ns/1ps
module adcseq_top_tb;

    localparam int GRP_W  = 1;
    localparam int SCAN_N = 4;
    localparam int RES_W  = 10;
    localparam int CH_W   = GRP_W + $clog2(SCAN_N);
    localparam int LAT    = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en_i = 1'b0;
    logic             start_wr_i = 1'b0;
    logic             start_val_i = 1'b0;
    logic             chsel_wr_i = 1'b0;
    logic [GRP_W-1:0] chsel_val_i = '0;
    logic             hw_trig_i = 1'b0;
    logic             conv_done_i = 1'b0;
    logic [RES_W-1:0] conv_data_i = '0;
    logic             conv_start_o;
    logic [CH_W-1:0]  conv_ch_o;
    logic [RES_W-1:0] result_o;
    logic             irq_o;
    logic [1:0]       state_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int irq_cnt = 0;
    int serial = 0;
    int cnt = 0;
    int started[$];
    bit cmp_on = 0;

    // Reference model state
    int m_st = 0, m_idx = 0, m_base = 0, m_cs = 0, m_irq = 0, m_res = 0;

    always #2 clk = ~clk;

    adcseq_top #(.GRP_W(GRP_W), .SCAN_N(SCAN_N), .RES_W(RES_W)) u_dut (.*);

    task automatic check(input string tag, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_sim();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Converter core model: done strobe LAT cycles after each start pulse.
    always @(negedge clk) begin
        if (!rst_n) begin
            cnt = 0;
            conv_done_i = 1'b0;
        end else if (conv_start_o) begin
            cnt = LAT;
            conv_done_i = 1'b0;
            serial++;
            conv_data_i = RES_W'((int'(conv_ch_o) << 7) | (serial & 127));
            started.push_back(int'(conv_ch_o));
        end else if (cnt > 0) begin
            cnt--;
            conv_done_i = (cnt == 0);
        end else begin
            conv_done_i = 1'b0;
        end
    end

    // Behavioural reference model, advanced on every rising edge.
    always @(posedge clk) begin
        cmp_on = 1;
        if (!rst_n) begin
            m_st = 0; m_idx = 0; m_base = 0; m_cs = 0; m_irq = 0; m_res = 0;
        end else begin
            bit wr_set, wr_clr, dn;
            wr_set = start_wr_i && start_val_i;
            wr_clr = start_wr_i && !start_val_i;
            dn = conv_done_i;
            m_irq = 0;
            if (!en_i) begin
                m_st = 0; m_cs = 0;
            end else if (m_st == 0) begin
                m_st = 1; m_cs = 0;
            end else if (m_st == 1) begin
                if (wr_set) begin m_st = 2; m_idx = 0; m_cs = 1; end
                else m_cs = 0;
            end else begin
                if (wr_clr) begin
                    m_st = 1; m_cs = 0;
                end else if (wr_set || chsel_wr_i) begin
                    m_idx = 0; m_cs = 1;
                end else if (dn && m_cs == 0) begin
                    m_res = int'(conv_data_i); m_irq = 1;
                    m_idx = (m_idx + 1) % SCAN_N; m_cs = 1;
                end else begin
                    m_cs = 0;
                end
            end
            if (chsel_wr_i) m_base = int'(chsel_val_i);
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            check("R3 state", int'(state_o) == m_st, int'(state_o), m_st);
            check("R12 start pulse", int'(conv_start_o) == m_cs, int'(conv_start_o), m_cs);
            check("R4 channel", int'(conv_ch_o) == m_base * SCAN_N + m_idx,
                  int'(conv_ch_o), m_base * SCAN_N + m_idx);
            check("R5 irq", int'(irq_o) == m_irq, int'(irq_o), m_irq);
            check("R5 result", int'(result_o) == m_res, int'(result_o), m_res);
            if (irq_o) irq_cnt++;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, 100000);
            finish_sim();
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wr_start(input bit v);
        start_wr_i = 1'b1; start_val_i = v;
        tick();
        start_wr_i = 1'b0;
    endtask

    task automatic wr_grp(input int g);
        chsel_wr_i = 1'b1; chsel_val_i = GRP_W'(g);
        tick();
        chsel_wr_i = 1'b0;
    endtask

    task automatic wait_mid();
        // Wait for a start pulse, then one more cycle: conversion in flight.
        while (!conv_start_o) tick();
        tick();
    endtask

    initial begin
        int base_irq;
        int saved;
        repeat (4) tick();
        // R1: reset state
        check("R1 state", state_o == 2'd0, int'(state_o), 0);
        check("R1 outputs", !conv_start_o && !irq_o && result_o == '0,
              int'(result_o), 0);
        rst_n = 1'b1;
        tick();
        check("R1 after release", state_o == 2'd0 && !irq_o, int'(state_o), 0);

        // R2: start write with enable low is ignored
        wr_start(1'b1);
        for (int i = 0; i < 4; i++) begin
            check("R2 stays stopped", state_o == 2'd0 && !conv_start_o,
                  int'(state_o), 0);
            tick();
        end

        // R3: enable moves to standby
        en_i = 1'b1;
        tick();
        check("R3 standby", state_o == 2'd1, int'(state_o), 1);

        // R4: start scan on group 0
        started.delete();
        wr_start(1'b1);
        check("R4 converting", state_o == 2'd2, int'(state_o), 2);
        check("R4 first pulse", conv_start_o && conv_ch_o == 0, int'(conv_ch_o), 0);
        irq_cnt = 0;
        while (irq_cnt < 8) tick();
        // R5 and R6: four interrupts per scan, wrap to index 0
        check("R5 eight irqs in two scans", irq_cnt == 8, irq_cnt, 8);
        for (int i = 0; i < 6; i++)
            check("R6 channel order", started[i] == i % 4, started[i], i % 4);

        // R9: hardware trigger pulses during the scan
        for (int i = 0; i < 24; i++) begin
            hw_trig_i = (i % 3 != 1);
            tick();
            check("R9 start only after result", !conv_start_o || irq_o,
                  int'(conv_start_o), int'(irq_o));
        end
        hw_trig_i = 1'b0;

        // R7: start rewrite mid-conversion restarts at index 0
        wait_mid();
        base_irq = irq_cnt;
        wr_start(1'b1);
        check("R7 restart pulse", conv_start_o && conv_ch_o == 0, int'(conv_ch_o), 0);
        check("R7 no irq", !irq_o, int'(irq_o), 0);

        // R8: same-value group write aborts
        wait_mid();
        wr_grp(0);
        check("R8 same group restart", conv_start_o && conv_ch_o == 0, int'(conv_ch_o), 0);
        // wait until index 2 is in flight, then switch group
        while (!(conv_start_o && conv_ch_o == 2)) tick();
        tick();
        wr_grp(1);
        check("R8 new group restart", conv_start_o && conv_ch_o == 4, int'(conv_ch_o), 4);

        // R11: group write on the done strobe cycle drops the result
        while (!conv_done_i) tick();
        saved = int'(result_o);
        base_irq = irq_cnt;
        wr_grp(1);
        check("R11 no irq on abort", !irq_o, int'(irq_o), 0);
        check("R11 result kept", int'(result_o) == saved, int'(result_o), saved);
        check("R11 restart", conv_start_o && conv_ch_o == 4, int'(conv_ch_o), 4);

        // R10: start clear with a group write halts and stores the group
        wait_mid();
        start_wr_i = 1'b1; start_val_i = 1'b0;
        chsel_wr_i = 1'b1; chsel_val_i = GRP_W'(0);
        tick();
        start_wr_i = 1'b0; chsel_wr_i = 1'b0;
        check("R10 standby", state_o == 2'd1, int'(state_o), 1);
        check("R10 no pulse", !conv_start_o && !irq_o, int'(conv_start_o), 0);
        base_irq = irq_cnt;
        repeat (LAT + 3) tick();
        // R12: the late done strobe of the aborted conversion is ignored
        check("R12 late done ignored", irq_cnt == base_irq, irq_cnt, base_irq);

        // Restart uses the group stored during the halt
        wr_start(1'b1);
        check("R10 group stored", conv_start_o && conv_ch_o == 0, int'(conv_ch_o), 0);
        while (irq_cnt < base_irq + 2) tick();

        // R3: disable while converting returns to stop
        en_i = 1'b0;
        tick();
        check("R3 stop on disable", state_o == 2'd0, int'(state_o), 0);
        repeat (LAT + 2) tick();
        check("R12 no pulse when stopped", !conv_start_o && !irq_o, int'(conv_start_o), 0);
        en_i = 1'b1;
        tick();
        check("R3 standby again", state_o == 2'd1, int'(state_o), 1);
        repeat (3) tick();
        finish_sim();
    end

endmodule